// File: doc/BRIEF.md
# Expansion Bus Window Translator

This block sits between a local processor bus and an external parallel expansion bus. Each local request is routed one of two ways. A request whose address falls in the 1 GB window from 0x8000_0000 to 0xBFFF_FFFF becomes a cycle on the external bus. Any other request goes unchanged to a default local slave port. One control bit sets the meaning of the window for each request at the moment it is accepted.

In memory mode the window becomes an external memory cycle. The 30 low address bits come from the request and the top two bits come from a control field. In configuration mode the same window becomes a configuration cycle. The block decodes a device number, a function number and a register number from the local offset. It then builds an external address that drives one device-select line high, one-hot, above the function and register fields. Configuration accesses can be one to four bytes wide: a sub-word read returns only the addressed lanes, and a sub-word write is done as a read-modify-write that keeps the other lanes.

A failed external cycle sets a sticky abort flag, and software clears it by writing one to it. Reads that fail return all ones. Device numbers that would place the select line at or above the 1 MB configuration span, or that exceed 18, are refused without any bus cycle.

Top module: `xbus_window_bridge`

## Requirements
- R1: A request with lcl_addr[31:30] == 2'b10 goes to the external bus. Any other request goes to the default port with dflt_addr, dflt_wdata and dflt_write equal to the request's values, and its read data is returned unchanged. ext_req and dflt_req are never high together.
- R2: In memory mode, ext_cfg is 0, ext_write follows the request, ext_wdata equals lcl_wdata, and ext_addr = {control bits 3:2, lcl_addr[29:0]}.
- R3: Control register (csr_sel = 0): bit 1 set to 1 selects configuration mode, and bits 3:2 supply the upper external address bits. On readback these three bits return their written values and every other bit reads 0. After reset both registers read 0.
- R4: In configuration mode, dev = lcl_addr[15:11], func = lcl_addr[10:8] and reg = lcl_addr[7:2]. The external address is ext_addr = (1 << (13 + dev)) | (func << 8) | (reg << 2), with ext_cfg = 1.
- R5: A configuration access is refused when (1 << (13 + dev)) >= 0x10_0000 or dev > 18. A refused access starts no external cycle, completes with lcl_err = 1 and read data 0xFFFF_FFFF, and leaves the abort flag unchanged. Device 6 is the highest one accepted.
- R6: When ext_ack arrives with ext_abort, status bit 26 (csr_sel = 1) is set. Writing 1 to bit 26 clears it, writing 0 leaves it alone, and if an abort and a clear happen in the same cycle the abort wins.
- R7: An external read that aborts, in either mode, completes with lcl_err = 1 and lcl_rdata = 0xFFFF_FFFF.
- R8: lcl_size holds the byte count minus 1, and lane = lcl_addr[1:0]. A configuration read returns (word >> 8*lane) & (0xFFFF_FFFF >> 8*(3 - lcl_size)).
- R9: A configuration write first reads the word and then writes (word & ~(mask << 8*lane)) | ((lcl_wdata & mask) << 8*lane), using the mask from R8. If the read aborts, the write cycle is not issued.
- R10: lcl_done is a one-cycle pulse for each accepted request. lcl_busy is high from the cycle after acceptance until completion. After reset ext_req, dflt_req, lcl_busy and lcl_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_valid | input | 1 | Request strobe, taken when lcl_busy is low |
| lcl_write | input | 1 | 1 = write, 0 = read |
| lcl_addr | input | 32 | Local byte address |
| lcl_wdata | input | 32 | Write data, right-aligned for sub-word configuration writes |
| lcl_size | input | 2 | Byte count minus 1 (configuration accesses) |
| lcl_busy | output | 1 | A request is in flight |
| lcl_done | output | 1 | Completion pulse |
| lcl_err | output | 1 | Completion with abort or refusal |
| lcl_rdata | output | 32 | Read data, valid with lcl_done |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 = control, 1 = status |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Selected register, one cycle after csr_sel |
| ext_req | output | 1 | External cycle request, held until ext_ack |
| ext_write | output | 1 | External write |
| ext_cfg | output | 1 | External cycle is a configuration cycle |
| ext_addr | output | 32 | External address |
| ext_wdata | output | 32 | External write data |
| ext_ack | input | 1 | External cycle complete |
| ext_abort | input | 1 | External cycle failed, qualified by ext_ack |
| ext_rdata | input | 32 | External read data |
| dflt_req | output | 1 | Default port request, held until dflt_ack |
| dflt_write | output | 1 | Default port write |
| dflt_addr | output | 32 | Default port address |
| dflt_wdata | output | 32 | Default port write data |
| dflt_ack | input | 1 | Default port complete |
| dflt_rdata | input | 32 | Default port read data |

## Verification
Several properties are checked on every cycle: only one of the two targets is ever requested at a time, configuration cycles always have exactly one select line high and stay inside the 1 MB span, an abort acknowledge is always followed by the flag being set, a write-one clear with no abort in the same cycle always clears it, failed completions always carry all ones, and completions last one cycle. Other behaviour needs the bench's scenarios: the exact composed addresses, the merged data of a read-modify-write, the lane extraction of sub-word reads, refused accesses producing no bus traffic, and the write phase being dropped after a failed read.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEM,
    ST_CFG_RD,
    ST_CFG_WR,
    ST_DFLT
  } xbw_state_e;
endpackage

// File: rtl/xbw_csr.sv
module xbw_csr #(
  parameter int DW        = 32,
  parameter int MODE_BIT  = 1,
  parameter int HI_LSB    = 2,
  parameter int ABORT_BIT = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  input  logic          abort_evt,
  output logic          cfg_mode,
  output logic [1:0]    hi_bits,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] MISC_MASK = (DW'(1) << MODE_BIT) | (DW'(3) << HI_LSB);

  logic [DW-1:0] misc_q;
  logic          abort_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q  <= '0;
      abort_q <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr && !sel) misc_q <= wdata & MISC_MASK;
      if (abort_evt) abort_q <= 1'b1;
      else if (wr && sel && wdata[ABORT_BIT]) abort_q <= 1'b0;
      rdata <= sel ? (DW'(abort_q) << ABORT_BIT) : misc_q;
    end
  end

  assign cfg_mode = misc_q[MODE_BIT];
  assign hi_bits  = misc_q[HI_LSB +: 2];

  // R6: an abort acknowledge always leaves the flag set
  assert_abort_capture_R6: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> abort_q);
  // R6: write-one clear takes effect when no abort competes
  assert_abort_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && sel && wdata[ABORT_BIT] && !abort_evt) |=> !abort_q);
endmodule

// File: rtl/xbw_decode.sv
module xbw_decode #(
  parameter int                AW       = 32,
  parameter logic [1:0]        WIN_TAG  = 2'b10,
  parameter int                DEV_W    = 5,
  parameter int                DEV_LSB  = 11,
  parameter int                SEL_BASE = 13,
  parameter int                MAX_DEV  = 18,
  parameter longint unsigned   CFG_SPAN = 64'h10_0000
) (
  input  logic [AW-1:0] addr,
  input  logic          cfg_mode,
  input  logic [1:0]    hi_bits,
  output logic          in_win,
  output logic          is_cfg,
  output logic          reject,
  output logic [AW-1:0] xaddr,
  output logic [1:0]    lane
);
  localparam int FLD_MSB = DEV_LSB - 1;

  logic [DEV_W-1:0] dev;
  logic [63:0]      sel_line;

  always_comb begin
    dev      = addr[DEV_LSB +: DEV_W];
    sel_line = 64'd1 << (SEL_BASE + int'(dev));
    in_win   = (addr[AW-1 -: 2] == WIN_TAG);
    is_cfg   = in_win && cfg_mode;
    reject   = is_cfg && ((sel_line >= CFG_SPAN) || (int'(dev) > MAX_DEV));
    lane     = addr[1:0];
    if (cfg_mode) xaddr = sel_line[AW-1:0] | AW'({addr[FLD_MSB:2], 2'b00});
    else          xaddr = {hi_bits, addr[AW-3:0]};
  end
endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
  import xbw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lcl_valid,
  input  logic          lcl_write,
  input  logic [AW-1:0] lcl_addr,
  input  logic [DW-1:0] lcl_wdata,
  input  logic [1:0]    lcl_size,
  input  logic          in_win,
  input  logic          is_cfg,
  input  logic          reject,
  input  logic [AW-1:0] xaddr,
  input  logic [1:0]    lane,
  output logic          lcl_busy,
  output logic          lcl_done,
  output logic          lcl_err,
  output logic [DW-1:0] lcl_rdata,
  output logic          ext_req,
  output logic          ext_write,
  output logic          ext_cfg,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic          ext_ack,
  input  logic          ext_abort,
  input  logic [DW-1:0] ext_rdata,
  output logic          dflt_req,
  output logic          dflt_write,
  output logic [AW-1:0] dflt_addr,
  output logic [DW-1:0] dflt_wdata,
  input  logic          dflt_ack,
  input  logic [DW-1:0] dflt_rdata,
  output logic          abort_evt
);
  xbw_state_e    st;
  logic          wr_q;
  logic [1:0]    lane_q, size_q;
  logic [DW-1:0] wdata_q;
  logic [4:0]    sh;
  logic [DW-1:0] msk, pick, merged;

  always_comb begin
    sh     = {lane_q, 3'b000};
    msk    = {DW{1'b1}} >> {~size_q, 3'b000};
    pick   = (ext_rdata >> sh) & msk;
    merged = (ext_rdata & ~(msk << sh)) | ((wdata_q & msk) << sh);
  end

  assign abort_evt = ext_req && ext_ack && ext_abort;
  assign lcl_busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      wr_q <= 1'b0; lane_q <= '0; size_q <= '0; wdata_q <= '0;
      lcl_done <= 1'b0; lcl_err <= 1'b0; lcl_rdata <= '0;
      ext_req <= 1'b0; ext_write <= 1'b0; ext_cfg <= 1'b0;
      ext_addr <= '0; ext_wdata <= '0;
      dflt_req <= 1'b0; dflt_write <= 1'b0; dflt_addr <= '0; dflt_wdata <= '0;
    end else begin
      lcl_done <= 1'b0;
      case (st)
        ST_IDLE: if (lcl_valid) begin
          wr_q <= lcl_write; lane_q <= lane; size_q <= lcl_size; wdata_q <= lcl_wdata;
          if (!in_win) begin
            dflt_req <= 1'b1; dflt_write <= lcl_write;
            dflt_addr <= lcl_addr; dflt_wdata <= lcl_wdata;
            st <= ST_DFLT;
          end else if (reject) begin
            lcl_done <= 1'b1; lcl_err <= 1'b1; lcl_rdata <= '1;
          end else if (is_cfg) begin
            ext_req <= 1'b1; ext_cfg <= 1'b1; ext_write <= 1'b0;
            ext_addr <= xaddr; ext_wdata <= '0;
            st <= ST_CFG_RD;
          end else begin
            ext_req <= 1'b1; ext_cfg <= 1'b0; ext_write <= lcl_write;
            ext_addr <= xaddr; ext_wdata <= lcl_wdata;
            st <= ST_MEM;
          end
        end
        ST_MEM: if (ext_ack) begin
          ext_req <= 1'b0; lcl_done <= 1'b1; lcl_err <= ext_abort;
          lcl_rdata <= ext_abort ? '1 : (wr_q ? '0 : ext_rdata);
          st <= ST_IDLE;
        end
        ST_CFG_RD: if (ext_ack) begin
          if (ext_abort) begin
            ext_req <= 1'b0; lcl_done <= 1'b1; lcl_err <= 1'b1; lcl_rdata <= '1;
            st <= ST_IDLE;
          end else if (wr_q) begin
            ext_write <= 1'b1; ext_wdata <= merged;
            st <= ST_CFG_WR;
          end else begin
            ext_req <= 1'b0; lcl_done <= 1'b1; lcl_err <= 1'b0; lcl_rdata <= pick;
            st <= ST_IDLE;
          end
        end
        ST_CFG_WR: if (ext_ack) begin
          ext_req <= 1'b0; ext_write <= 1'b0; lcl_done <= 1'b1; lcl_err <= ext_abort;
          lcl_rdata <= ext_abort ? '1 : '0;
          st <= ST_IDLE;
        end
        ST_DFLT: if (dflt_ack) begin
          dflt_req <= 1'b0; lcl_done <= 1'b1; lcl_err <= 1'b0;
          lcl_rdata <= wr_q ? '0 : dflt_rdata;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: every failed completion carries all-ones data
  assert_fail_data_R7: assert property (@(posedge clk) disable iff (rst)
    (lcl_done && lcl_err) |-> (lcl_rdata == {DW{1'b1}}));
  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    lcl_done |=> !lcl_done);
  // R9: a write phase only follows a clean read phase
  assert_wr_after_rd_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_req && ext_cfg && !ext_write && ext_ack && ext_abort) |=> !ext_req);
endmodule

// File: rtl/xbus_window_bridge.sv
module xbus_window_bridge #(
  parameter int              AW        = 32,
  parameter int              DW        = 32,
  parameter logic [1:0]      WIN_TAG   = 2'b10,
  parameter int              DEV_W     = 5,
  parameter int              DEV_LSB   = 11,
  parameter int              SEL_BASE  = 13,
  parameter int              MAX_DEV   = 18,
  parameter longint unsigned CFG_SPAN  = 64'h10_0000,
  parameter int              MODE_BIT  = 1,
  parameter int              HI_LSB    = 2,
  parameter int              ABORT_BIT = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lcl_valid,
  input  logic          lcl_write,
  input  logic [AW-1:0] lcl_addr,
  input  logic [DW-1:0] lcl_wdata,
  input  logic [1:0]    lcl_size,
  output logic          lcl_busy,
  output logic          lcl_done,
  output logic          lcl_err,
  output logic [DW-1:0] lcl_rdata,
  input  logic          csr_wr,
  input  logic          csr_sel,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  output logic          ext_req,
  output logic          ext_write,
  output logic          ext_cfg,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic          ext_ack,
  input  logic          ext_abort,
  input  logic [DW-1:0] ext_rdata,
  output logic          dflt_req,
  output logic          dflt_write,
  output logic [AW-1:0] dflt_addr,
  output logic [DW-1:0] dflt_wdata,
  input  logic          dflt_ack,
  input  logic [DW-1:0] dflt_rdata
);
  logic          cfg_mode, in_win, is_cfg, reject, abort_evt;
  logic [1:0]    hi_bits, lane;
  logic [AW-1:0] xaddr;

  xbw_csr #(.DW(DW), .MODE_BIT(MODE_BIT), .HI_LSB(HI_LSB), .ABORT_BIT(ABORT_BIT)) u_csr (
    .clk(clk), .rst(rst), .wr(csr_wr), .sel(csr_sel), .wdata(csr_wdata),
    .abort_evt(abort_evt), .cfg_mode(cfg_mode), .hi_bits(hi_bits), .rdata(csr_rdata)
  );

  xbw_decode #(.AW(AW), .WIN_TAG(WIN_TAG), .DEV_W(DEV_W), .DEV_LSB(DEV_LSB),
               .SEL_BASE(SEL_BASE), .MAX_DEV(MAX_DEV), .CFG_SPAN(CFG_SPAN)) u_decode (
    .addr(lcl_addr), .cfg_mode(cfg_mode), .hi_bits(hi_bits), .in_win(in_win),
    .is_cfg(is_cfg), .reject(reject), .xaddr(xaddr), .lane(lane)
  );

  xbw_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .lcl_valid(lcl_valid), .lcl_write(lcl_write),
    .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata), .lcl_size(lcl_size),
    .in_win(in_win), .is_cfg(is_cfg), .reject(reject), .xaddr(xaddr), .lane(lane),
    .lcl_busy(lcl_busy), .lcl_done(lcl_done), .lcl_err(lcl_err), .lcl_rdata(lcl_rdata),
    .ext_req(ext_req), .ext_write(ext_write), .ext_cfg(ext_cfg), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_abort(ext_abort), .ext_rdata(ext_rdata),
    .dflt_req(dflt_req), .dflt_write(dflt_write), .dflt_addr(dflt_addr),
    .dflt_wdata(dflt_wdata), .dflt_ack(dflt_ack), .dflt_rdata(dflt_rdata),
    .abort_evt(abort_evt)
  );

  // R1: the two targets are never requested together, and the default port never sees window addresses
  assert_single_target_R1: assert property (@(posedge clk) disable iff (rst)
    !(ext_req && dflt_req));
  assert_dflt_outside_R1: assert property (@(posedge clk) disable iff (rst)
    dflt_req |-> (dflt_addr[AW-1 -: 2] != WIN_TAG));
  // R4: a configuration cycle drives exactly one select line
  assert_cfg_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    (ext_req && ext_cfg) |-> $onehot(ext_addr[AW-1:SEL_BASE]));
  // R5: no configuration cycle leaves the permitted span
  assert_cfg_span_R5: assert property (@(posedge clk) disable iff (rst)
    (ext_req && ext_cfg) |-> (64'(ext_addr) < CFG_SPAN));
endmodule

// File: tb/xbus_window_bridge_bench.sv
module xbus_window_bridge_bench;
  localparam int LAT = 2;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        lcl_valid = 0, lcl_write = 0;
  logic [31:0] lcl_addr = 0, lcl_wdata = 0;
  logic [1:0]  lcl_size = 0;
  logic        lcl_busy, lcl_done, lcl_err;
  logic [31:0] lcl_rdata;
  logic        csr_wr = 0, csr_sel = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        ext_req, ext_write, ext_cfg;
  logic [31:0] ext_addr, ext_wdata;
  logic        ext_ack = 0, ext_abort = 0;
  logic [31:0] ext_rdata = 0;
  logic        dflt_req, dflt_write;
  logic [31:0] dflt_addr, dflt_wdata;
  logic        dflt_ack = 0;
  logic [31:0] dflt_rdata = 0;

  xbus_window_bridge u_xbus_window_bridge (
    .clk(clk), .rst(rst), .lcl_valid(lcl_valid), .lcl_write(lcl_write),
    .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata), .lcl_size(lcl_size),
    .lcl_busy(lcl_busy), .lcl_done(lcl_done), .lcl_err(lcl_err), .lcl_rdata(lcl_rdata),
    .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ext_req(ext_req), .ext_write(ext_write), .ext_cfg(ext_cfg), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_abort(ext_abort), .ext_rdata(ext_rdata),
    .dflt_req(dflt_req), .dflt_write(dflt_write), .dflt_addr(dflt_addr),
    .dflt_wdata(dflt_wdata), .dflt_ack(dflt_ack), .dflt_rdata(dflt_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", cyc, WD_LIMIT);
      summary();
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] cfg_store [int unsigned];
  logic        eq_w[$], eq_c[$];
  logic [31:0] eq_a[$], eq_d[$];
  string       eq_t[$];
  int          ext_seen = 0, dflt_seen = 0, wcnt = 0, dcnt = 0;
  logic        last_dw;
  logic [31:0] last_da, last_dd;

  function automatic logic [31:0] cfg_get(input logic [31:0] a);
    if (cfg_store.exists(a)) return cfg_store[a];
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic int cfg_dev(input logic [31:0] a);
    for (int i = 31; i >= 13; i--) if (a[i]) return i - 13;
    return -1;
  endfunction

  function automatic bit dev_present(input int d);
    return (d == 1) || (d == 2) || (d == 6);
  endfunction

  function automatic logic [31:0] cfg_local(input int d, input int f, input int r, input int ln);
    return 32'h8000_0000 | (32'(d) << 11) | (32'(f) << 8) | (32'(r) << 2) | 32'(ln);
  endfunction

  function automatic logic [31:0] cfg_ext(input int d, input int f, input int r);
    return (32'd1 << (13 + d)) | (32'(f) << 8) | (32'(r) << 2);
  endfunction

  function automatic logic [31:0] lane_mask(input int sz);
    return 32'hFFFF_FFFF >> (8 * (3 - sz));
  endfunction

  task automatic expect_ext(input logic w, input logic c, input logic [31:0] a,
                            input logic [31:0] d, input string t);
    eq_w.push_back(w); eq_c.push_back(c); eq_a.push_back(a); eq_d.push_back(d); eq_t.push_back(t);
  endtask

  // external bus responder, compared against the expected-cycle queue each clock
  always @(negedge clk) begin
    if (rst) begin
      ext_ack = 0; ext_abort = 0; wcnt = 0;
    end else begin
      if (ext_req && dflt_req) chk(0, "R1 both targets", 1, 0);
      if (ext_ack) begin
        ext_ack = 0; ext_abort = 0; wcnt = 0;
      end else if (ext_req) begin
        if (wcnt == 0) begin
          ext_seen++;
          if (eq_a.size() == 0) chk(0, "R1 unexpected external cycle", ext_addr, 0);
          else begin
            string t;
            logic w, c; logic [31:0] a, d;
            w = eq_w.pop_front(); c = eq_c.pop_front(); a = eq_a.pop_front();
            d = eq_d.pop_front(); t = eq_t.pop_front();
            chk(ext_addr == a, {t, " ext_addr"}, ext_addr, a);
            chk(ext_write == w && ext_cfg == c, {t, " ext kind"}, {30'd0, ext_write, ext_cfg}, {30'd0, w, c});
            chk(ext_wdata == d, {t, " ext_wdata"}, ext_wdata, d);
          end
        end
        if (wcnt == LAT) begin
          if (ext_cfg) ext_abort = !dev_present(cfg_dev(ext_addr));
          else         ext_abort = (ext_addr[31:30] == 2'b01);
          if (!ext_abort && ext_write && ext_cfg) cfg_store[ext_addr] = ext_wdata;
          ext_rdata = ext_cfg ? cfg_get(ext_addr) : (ext_addr ^ 32'h5A5A_0000);
          ext_ack = 1;
        end else wcnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      dflt_ack = 0; dcnt = 0;
    end else if (dflt_ack) begin
      dflt_ack = 0; dcnt = 0;
    end else if (dflt_req) begin
      if (dcnt == 0) begin
        dflt_seen++; last_dw = dflt_write; last_da = dflt_addr; last_dd = dflt_wdata;
      end
      if (dcnt == 1) begin dflt_rdata = ~dflt_addr; dflt_ack = 1; end
      else dcnt++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, output logic [31:0] rd, output logic er);
    int n;
    @(negedge clk);
    lcl_valid = 1; lcl_write = w; lcl_addr = a; lcl_wdata = d; lcl_size = sz;
    @(negedge clk);
    lcl_valid = 0;
    n = 0;
    while (!lcl_done && n < 50) begin
      if (n == 0) chk(lcl_busy == 1'b1, "R10 busy while in flight", lcl_busy, 1);
      @(negedge clk); n++;
    end
    chk(lcl_done == 1'b1, "R10 completion seen", lcl_done, 1);
    rd = lcl_rdata; er = lcl_err;
    @(negedge clk);
    chk(lcl_done == 1'b0, "R10 done is one cycle", lcl_done, 0);
  endtask

  task automatic csr_write(input logic s, input logic [31:0] d);
    @(negedge clk); csr_wr = 1; csr_sel = s; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic csr_read(input logic s, output logic [31:0] v);
    @(negedge clk); csr_sel = s;
    @(negedge clk); v = csr_rdata;
  endtask

  task automatic cfg_read(input int dv, input int f, input int r, input int ln, input int sz,
                          input string t);
    logic [31:0] rd, xa, ex; logic er;
    xa = cfg_ext(dv, f, r);
    expect_ext(0, 1, xa, 0, t);
    if (dev_present(dv)) ex = (cfg_get(xa) >> (8 * ln)) & lane_mask(sz);
    else ex = 32'hFFFF_FFFF;
    access(0, cfg_local(dv, f, r, ln), 0, 2'(sz), rd, er);
    chk(rd == ex, {t, " read data"}, rd, ex);
    chk(er == !dev_present(dv), {t, " err"}, {31'd0, er}, {31'd0, !dev_present(dv)});
  endtask

  task automatic cfg_write(input int dv, input int f, input int r, input int ln, input int sz,
                           input logic [31:0] d, input string t);
    logic [31:0] rd, xa, old, m, mg; logic er;
    xa = cfg_ext(dv, f, r);
    old = cfg_get(xa);
    m = lane_mask(sz);
    mg = (old & ~(m << (8 * ln))) | ((d & m) << (8 * ln));
    expect_ext(0, 1, xa, 0, t);
    if (dev_present(dv)) expect_ext(1, 1, xa, mg, t);
    access(1, cfg_local(dv, f, r, ln), d, 2'(sz), rd, er);
    chk(er == !dev_present(dv), {t, " err"}, {31'd0, er}, {31'd0, !dev_present(dv)});
  endtask

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] v, rd; logic er; int s0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({ext_req, dflt_req, lcl_busy, lcl_done} == 4'b0, "R10 reset outputs",
        {28'd0, ext_req, dflt_req, lcl_busy, lcl_done}, 0);
    csr_read(0, v); chk(v == 0, "R3 control after reset", v, 0);
    csr_read(1, v); chk(v == 0, "R6 status after reset", v, 0);

    // R1: outside the window
    access(0, 32'h1234_5678, 0, 2'd3, rd, er);
    chk(rd == 32'hEDCB_A987 && !er, "R1 default read data", rd, 32'hEDCB_A987);
    chk(last_da == 32'h1234_5678 && !last_dw, "R1 default read address", last_da, 32'h1234_5678);
    access(1, 32'hC000_0010, 32'hCAFE_F00D, 2'd3, rd, er);
    chk(last_da == 32'hC000_0010 && last_dw, "R1 default write address", last_da, 32'hC000_0010);
    chk(last_dd == 32'hCAFE_F00D, "R1 default write data", last_dd, 32'hCAFE_F00D);
    chk(ext_seen == 0, "R1 no external cycle", ext_seen, 0);
    chk(dflt_seen == 2, "R1 default cycles", dflt_seen, 2);

    // R2: memory mode address composition
    expect_ext(0, 0, 32'h0000_1000, 0, "R2 hi=0");
    access(0, 32'h8000_1000, 0, 2'd3, rd, er);
    chk(rd == 32'h5A5A_1000 && !er, "R2 read data hi=0", rd, 32'h5A5A_1000);
    csr_write(0, 32'h0000_000C);
    expect_ext(0, 0, 32'hFFFF_FFFC, 0, "R2 hi=3");
    access(0, 32'hBFFF_FFFC, 0, 2'd3, rd, er);
    chk(rd == 32'hA5A5_FFFC, "R2 read data hi=3", rd, 32'hA5A5_FFFC);
    csr_write(0, 32'h0000_0008);
    expect_ext(1, 0, 32'h8000_0040, 32'h1122_3344, "R2 write hi=2");
    access(1, 32'h8000_0040, 32'h1122_3344, 2'd3, rd, er);
    chk(!er, "R2 write ok", {31'd0, er}, 0);

    // R7 / R6: memory abort and the sticky flag
    csr_write(0, 32'h0000_0004);
    expect_ext(0, 0, 32'h4000_0100, 0, "R7 mem abort");
    access(0, 32'h8000_0100, 0, 2'd3, rd, er);
    chk(rd == 32'hFFFF_FFFF && er, "R7 mem abort data", rd, 32'hFFFF_FFFF);
    csr_read(1, v); chk(v == 32'h0400_0000, "R6 flag set", v, 32'h0400_0000);
    csr_write(1, 32'hFBFF_FFFF);
    csr_read(1, v); chk(v == 32'h0400_0000, "R6 write zero keeps flag", v, 32'h0400_0000);
    csr_write(1, 32'h0400_0000);
    csr_read(1, v); chk(v == 0, "R6 write one clears", v, 0);

    // R3: control readback
    csr_write(0, 32'hFFFF_FFFF);
    csr_read(0, v); chk(v == 32'h0000_000E, "R3 readback", v, 32'h0000_000E);
    csr_write(0, 32'h0000_0002);
    csr_read(0, v); chk(v == 32'h0000_0002, "R3 config mode", v, 32'h0000_0002);

    // R4 / R8: configuration reads
    cfg_read(1, 2, 16, 0, 3, "R4 word dev1");
    cfg_read(2, 7, 63, 0, 3, "R4 word dev2 top fields");
    cfg_read(6, 0, 1, 0, 3, "R5 highest accepted dev6");
    cfg_read(1, 2, 16, 3, 0, "R8 byte lane3");
    cfg_read(1, 2, 16, 2, 1, "R8 half lane2");
    cfg_read(2, 1, 5, 1, 0, "R8 byte lane1");

    // R9: read-modify-write
    cfg_write(2, 0, 4, 1, 0, 32'h0000_00AB, "R9 byte write");
    cfg_read(2, 0, 4, 0, 3, "R9 byte write merged");
    cfg_write(1, 3, 9, 2, 1, 32'hFFFF_5678, "R9 half write");
    cfg_read(1, 3, 9, 0, 3, "R9 half write merged");
    cfg_write(6, 1, 2, 0, 3, 32'hDEAD_BEEF, "R9 word write");
    cfg_read(6, 1, 2, 0, 3, "R9 word write merged");

    // R7: configuration abort
    cfg_read(5, 0, 0, 0, 3, "R7 cfg abort read");
    csr_read(1, v); chk(v == 32'h0400_0000, "R6 cfg abort flag", v, 32'h0400_0000);
    csr_write(1, 32'h0400_0000);
    s0 = ext_seen;
    cfg_write(3, 0, 0, 0, 3, 32'h1, "R9 abort drops write");
    chk(ext_seen == s0 + 1, "R9 only read phase", ext_seen, s0 + 1);
    csr_write(1, 32'h0400_0000);

    // R5: refused device numbers
    s0 = ext_seen;
    access(0, cfg_local(7, 0, 0, 0), 0, 2'd3, rd, er);
    chk(rd == 32'hFFFF_FFFF && er, "R5 dev7 refused", rd, 32'hFFFF_FFFF);
    access(1, cfg_local(20, 1, 1, 0), 32'h5, 2'd3, rd, er);
    chk(er, "R5 dev20 refused", {31'd0, er}, 1);
    access(0, cfg_local(31, 0, 0, 0), 0, 2'd3, rd, er);
    chk(rd == 32'hFFFF_FFFF && er, "R5 dev31 refused", rd, 32'hFFFF_FFFF);
    chk(ext_seen == s0, "R5 no bus cycle", ext_seen, s0);
    csr_read(1, v); chk(v == 0, "R5 flag untouched", v, 0);

    // R1 again in configuration mode: outside window unaffected
    access(0, 32'h0000_0800, 0, 2'd3, rd, er);
    chk(rd == 32'hFFFF_F7FF && last_da == 32'h0000_0800, "R1 default in cfg mode", rd, 32'hFFFF_F7FF);

    repeat (4) @(negedge clk);
    chk(eq_a.size() == 0, "R4 all expected cycles seen", eq_a.size(), 0);
    summary();
  end
endmodule